// File: doc/BRIEF.md
# BCD to Seven-Segment Latch-Decoder

This block turns one binary-coded decimal digit into the seven active-high drive lines of a common-cathode segment display. A four-bit storage stage sits in front of the decoder. While the active-low latch enable is asserted, the stage reloads on every clock edge, so the display follows the input one cycle later. When the enable is released, the stage keeps the digit it loaded last. The display then stays steady while the input bus carries other traffic.

Two active-low overrides act on the output after the decoder. The lamp test lights every segment, so a user can spot a dead segment. The blanking input switches every segment off, for example to suppress leading zeros. Lamp test wins over blanking, and blanking wins over the decoded glyph. Neither override touches the stored digit. The six codes above nine decode to a dark display.

Top module: `seg7_latch_decoder`

## Requirements
- R1: With `latchEnN` low at a rising clock edge, `segOut` after that edge shows the glyph of the `digitIn` value sampled at that edge, when both overrides are inactive.
- R2: With `latchEnN` high at a rising edge, the stored digit is unchanged, whatever `digitIn` does.
- R3: After `latchEnN` goes high, the display holds the digit sampled at the last edge where `latchEnN` was low.
- R4: While `lampTestN` is low, `segOut` is 7'h7F, whatever the other inputs are.
- R5: While `lampTestN` is high and `blankN` is low, `segOut` is 7'h00.
- R6: The overrides never change the stored digit. Loading continues under an override, and releasing the override shows the stored digit again.
- R7: Codes 10 to 15 decode to 7'h00.
- R8: Bit 0 of `segOut` is segment a and bit 6 is segment g. Digits 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F and 67 in hex. Digit 6 has no top bar and digit 9 has no bottom bar.
- R9: A synchronous active-high `rst` clears the stored digit to 0, so `segOut` shows 7'h3F when no override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| digitIn | input | 4 | BCD digit, bit 0 least significant |
| latchEnN | input | 1 | Active-low load enable of the storage stage |
| lampTestN | input | 1 | Active-low force-all-on |
| blankN | input | 1 | Active-low force-all-off |
| segOut | output | 7 | Segment drives a (bit 0) to g (bit 6), active high |

## Verification
The only internal state is the stored digit. A wrong value shows up on `segOut` in the first cycle in which both overrides are inactive. This holds when the digit was corrupted during a hold or while an override was active. The bench therefore always releases the overrides before it judges storage behaviour. Decode errors appear one edge after the faulty code is loaded, because the decoder reads only the register. Override errors appear in the same cycle, because the override stage is combinational.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam int NUM_CODES = 1 << DIGIT_W;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;

  localparam seg_t SEG_ALL_ON  = {SEG_W{1'b1}};
  localparam seg_t SEG_ALL_OFF = {SEG_W{1'b0}};

  // strobes from control to datapath
  typedef struct packed {
    logic clearDigit;
    logic loadDigit;
    logic forceOn;
    logic forceOff;
  } seg7_ctrl_t;

  // glyph table, bit 0 = segment a
  function automatic seg_t glyphOf(digit_t code);
    seg_t g;
    case (code)
      4'd0: g = 7'h3F;
      4'd1: g = 7'h06;
      4'd2: g = 7'h5B;
      4'd3: g = 7'h4F;
      4'd4: g = 7'h66;
      4'd5: g = 7'h6D;
      4'd6: g = 7'h7C;
      4'd7: g = 7'h07;
      4'd8: g = 7'h7F;
      4'd9: g = 7'h67;
      default: g = SEG_ALL_OFF;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg7_ctrl.sv
module seg7_ctrl
  import seg7_pkg::*;
(
  input  logic       rst,
  input  logic       latchEnN,
  input  logic       lampTestN,
  input  logic       blankN,
  output seg7_ctrl_t strobes
);
  always_comb begin
    strobes = '0;
    // reset outranks loading
    strobes.clearDigit = rst;
    strobes.loadDigit  = !rst && !latchEnN;
    // lamp test outranks blanking
    strobes.forceOn    = !lampTestN;
    strobes.forceOff   = lampTestN && !blankN;
  end
endmodule

// File: rtl/seg7_datapath.sv
module seg7_datapath
  import seg7_pkg::*;
#(
  parameter digit_t RESET_DIGIT = '0
) (
  input  logic       clk,
  input  seg7_ctrl_t strobes,
  input  digit_t     digitIn,
  output seg_t       segOut
);
  digit_t heldDigit;
  seg_t   glyph;

  always_ff @(posedge clk) begin
    if (strobes.clearDigit)     heldDigit <= RESET_DIGIT;
    else if (strobes.loadDigit) heldDigit <= digitIn;
  end

  always_comb glyph = glyphOf(heldDigit);

  always_comb begin
    if (strobes.forceOn)       segOut = SEG_ALL_ON;
    else if (strobes.forceOff) segOut = SEG_ALL_OFF;
    else                       segOut = glyph;
  end
endmodule

// File: rtl/seg7_latch_decoder.sv
module seg7_latch_decoder
  import seg7_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIGIT_W-1:0] digitIn,
  input  logic             latchEnN,
  input  logic             lampTestN,
  input  logic             blankN,
  output logic [SEG_W-1:0] segOut
);
  seg7_ctrl_t strobes;

  seg7_ctrl u_ctrl (
    .rst(rst), .latchEnN(latchEnN), .lampTestN(lampTestN),
    .blankN(blankN), .strobes(strobes)
  );

  seg7_datapath u_dp (
    .clk(clk), .strobes(strobes), .digitIn(digitIn), .segOut(segOut)
  );
endmodule

// File: rtl/seg7_checker.sv
module seg7_checker
  import seg7_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [DIGIT_W-1:0] digitIn,
  input logic             latchEnN,
  input logic             lampTestN,
  input logic             blankN,
  input logic [SEG_W-1:0] segOut
);
  // R4
  lamp_all_on_chk: assert property (@(posedge clk) disable iff (rst)
    !lampTestN |-> segOut == 7'h7F);

  // R5
  blank_all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (lampTestN && !blankN) |-> segOut == 7'h00);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(latchEnN) && lampTestN && blankN
     && $past(lampTestN) && $past(blankN)) |-> $stable(segOut));

  // R7
  nonbcd_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(latchEnN) && $past(digitIn) >= 4'd10
     && lampTestN && blankN) |-> segOut == 7'h00);

  // R1
  bcd_lit_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(latchEnN) && $past(digitIn) < 4'd10
     && lampTestN && blankN) |-> segOut != 7'h00);

  // R9
  reset_zero_chk: assert property (@(posedge clk)
    ($past(rst) && lampTestN && blankN) |-> segOut == 7'h3F);
endmodule

bind seg7_latch_decoder seg7_checker u_chk (
  .clk(clk), .rst(rst), .digitIn(digitIn), .latchEnN(latchEnN),
  .lampTestN(lampTestN), .blankN(blankN), .segOut(segOut)
);

// File: tb/sim_seg7_latch_decoder.sv
module sim_seg7_latch_decoder;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] digitIn;
  logic       latchEnN, lampTestN, blankN;
  logic [6:0] segOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg7_latch_decoder u0 (
    .clk(clk), .rst(rst), .digitIn(digitIn), .latchEnN(latchEnN),
    .lampTestN(lampTestN), .blankN(blankN), .segOut(segOut)
  );

  // expected glyphs for codes 0..15 (R8, R7)
  localparam logic [6:0] EXPECT [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7C, 7'h07,
    7'h7F, 7'h67, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00
  };

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (segOut !== exp) begin
      errors++;
      $display("FAIL %s segOut=%h expected=%h", req, segOut, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog segOut=%h expected=done", segOut);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; digitIn = 4'd5; latchEnN = 0; lampTestN = 1; blankN = 1;
    step;
    check("R9 reset shows zero", 7'h3F);
    rst = 0;

    // transparent walk over all codes
    for (int i = 0; i < 16; i++) begin
      digitIn = 4'(i);
      step;
      check(i < 10 ? "R1 R8 transparent glyph" : "R7 non-BCD dark", EXPECT[i]);
    end

    // capture and hold
    digitIn = 4'd3; step;
    check("R1 load 3", EXPECT[3]);
    latchEnN = 1; digitIn = 4'd8; step;
    check("R2 hold after rise", EXPECT[3]);
    digitIn = 4'd1; step;
    check("R3 held last loaded digit", EXPECT[3]);

    // override combinations while holding
    lampTestN = 0; blankN = 1; digitIn = 4'd6; step;
    check("R4 lamp test", 7'h7F);
    blankN = 0; #1;
    check("R4 lamp test beats blank", 7'h7F);
    lampTestN = 1; #1;
    check("R5 blank", 7'h00);
    step;
    blankN = 1; #1;
    check("R6 release shows held", EXPECT[3]);

    // loading continues under override
    latchEnN = 0; blankN = 0; digitIn = 4'd9; step;
    check("R5 blank while loading", 7'h00);
    latchEnN = 1; digitIn = 4'd2; step;
    blankN = 1; #1;
    check("R6 digit loaded under blank", EXPECT[9]);
    lampTestN = 0; step;
    lampTestN = 1; #1;
    check("R6 lamp test keeps digit", EXPECT[9]);

    // non-BCD code held
    latchEnN = 0; digitIn = 4'd12; step;
    latchEnN = 1; digitIn = 4'd0; step;
    check("R7 held non-BCD dark", 7'h00);

    // reset while holding
    rst = 1; step; rst = 0;
    check("R9 reset clears held", 7'h3F);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule